// File: doc/BRIEF.md
# Four-Group Carry Lookahead Generator with Wide Adder Wrapper

A combinational lookahead cell, `cla_lookahead4`, takes four group propagate/generate pairs from 4-bit adder slices and one incoming carry. It returns the carries into the second, third and fourth groups at once, plus a block-level propagate/generate pair. The group pairs and the block pair are active low, where 0 means asserted. The carries are active high. The cell produces no carry out of the block. That carry is rebuilt outside from the block pair and the incoming carry, so the same cell can feed a second lookahead level or ripple into a next 16-bit block.

The top module `cla_adder_wide` builds an adder of `WIDTH` bits, a multiple of 4, from 4-bit slices. It groups them four at a time under one lookahead cell per 16-bit block. The parameter `LEVELS` chooses how the block carries are formed:
- `LEVELS = 1`: the carry ripples from one 16-bit block to the next.
- `LEVELS = 2`: a second lookahead cell anticipates the carry into each block. This supports up to 64 bits.

A slice position left empty in the last block, as in a 28-bit word, is tied to "propagate asserted, generate deasserted". The block outputs therefore pass the true carry out of the highest real slice.

No clock, no reset and no stored state are involved. Every output is a function of the present inputs.

Top module: `cla_adder_wide`

## Requirements
- R1: In the lookahead cell, the carry into group 1 is 1 exactly when generate 0 is asserted (gen_n[0]=0), or when propagate 0 is asserted (prop_n[0]=0) and the carry input is 1.
- R2: The carry into group 2 is 1 exactly when gen_n[1]=0, or when prop_n[1]=0 and the carry into group 1 is 1.
- R3: The carry into group 3 is 1 exactly when gen_n[2]=0, or when prop_n[2]=0 and the carry into group 2 is 1.
- R4: The block generate output is 0 (asserted) exactly when group 3 generates, or when group 3 propagates a generate from group 2, 1 or 0 through every group above it. It never depends on the carry input.
- R5: The block propagate output is 0 (asserted) only when all four prop_n bits are 0.
- R6: `{carry_out, sum}` equals `op_a + op_b + carry_in` for every operand pair, at 16 and 32 bits.
- R7: With `LEVELS = 2`, the sum and the carry out equal those of the rippled arrangement for the same operands.
- R8: All-ones plus zero with carry_in = 1, and all-ones plus one, both give a zero sum and carry_out = 1. The carry passes through every group.
- R9: At 28 bits, the empty slice positions of the last block leave `carry_out` equal to the carry out of bit 27.
- R10: A generate in any one slice, with every higher slice propagating, gives carry_out = 1 and zero sum bits from that slice upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0, active high |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit, active high |

## Verification
The block holds no state, so a wrong term in a lookahead equation appears on the carry or block outputs in the same evaluation as the input pattern that exercises it, and nothing can hide it later. The lookahead cell is driven through all 512 combinations of its nine inputs, which reaches every product term. Wrong padding of an empty slice or a misrouted block carry shows up as a bad carry_out or upper sum bits at 28 bits, or when a carry must cross a 16-bit boundary, which the all-ones and single-generate patterns force.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int SLICE_W   = 4;
    localparam int LA_GROUPS = 4;
    localparam int BLOCK_W   = SLICE_W * LA_GROUPS;
endpackage

// File: rtl/cla_slice4.sv
module cla_slice4
    import cla_pkg::*;
(
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               c_in,
    output logic [SLICE_W-1:0] s,
    output logic               gen_n,
    output logic               prop_n
);
    logic [SLICE_W-1:0] bit_p;
    logic [SLICE_W-1:0] bit_g;
    logic [SLICE_W:0]   chain;
    logic [SLICE_W:0]   chain0;

    always_comb begin
        bit_p     = a ^ b;
        bit_g     = a & b;
        chain[0]  = c_in;
        chain0[0] = 1'b0;
        for (int i = 0; i < SLICE_W; i++) begin
            chain[i+1]  = bit_g[i] | (bit_p[i] & chain[i]);
            chain0[i+1] = bit_g[i] | (bit_p[i] & chain0[i]);
        end
        s      = bit_p ^ chain[SLICE_W-1:0];
        gen_n  = ~chain0[SLICE_W];
        prop_n = ~(&bit_p);
    end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4
    import cla_pkg::*;
(
    input  logic [LA_GROUPS-1:0] grp_gen_n,
    input  logic [LA_GROUPS-1:0] grp_prop_n,
    input  logic                 c_in,
    output logic [LA_GROUPS-2:0] c_grp,
    output logic                 blk_gen_n,
    output logic                 blk_prop_n
);
    logic [LA_GROUPS-1:0] g;
    logic [LA_GROUPS-1:0] p;
    logic                 acc;
    logic                 prod;

    // Flattened sum-of-products: every carry is two gate levels from the inputs.
    always_comb begin
        g = ~grp_gen_n;
        p = ~grp_prop_n;
        for (int k = 1; k < LA_GROUPS; k++) begin
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                prod = g[j];
                for (int m = j + 1; m < k; m++) prod = prod & p[m];
                acc = acc | prod;
            end
            prod = c_in;
            for (int m = 0; m < k; m++) prod = prod & p[m];
            c_grp[k-1] = acc | prod;
        end
        acc = 1'b0;
        for (int j = 0; j < LA_GROUPS; j++) begin
            prod = g[j];
            for (int m = j + 1; m < LA_GROUPS; m++) prod = prod & p[m];
            acc = acc | prod;
        end
        blk_gen_n  = ~acc;
        blk_prop_n = ~(&p);
    end
endmodule

// File: rtl/cla_adder_wide.sv
module cla_adder_wide
    import cla_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int LEVELS = 1
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int SLICES  = WIDTH / SLICE_W;
    localparam int BLOCKS  = (SLICES + LA_GROUPS - 1) / LA_GROUPS;
    localparam int PSLICES = BLOCKS * LA_GROUPS;

    logic [PSLICES-1:0]           l_gen_n;
    logic [PSLICES-1:0]           l_prop_n;
    logic [BLOCKS-1:0]            b_gen_n;
    logic [BLOCKS-1:0]            b_prop_n;
    logic [BLOCKS:0]              blk_cin;
    logic [BLOCKS*(LA_GROUPS-1)-1:0] lk_c;

    assign blk_cin[0] = carry_in;

    for (genvar s = 0; s < PSLICES; s++) begin : g_slice
        if (s < SLICES) begin : g_real
            logic sc;
            if (s % LA_GROUPS == 0) begin : g_head
                assign sc = blk_cin[s / LA_GROUPS];
            end else begin : g_inner
                assign sc = lk_c[(s / LA_GROUPS) * (LA_GROUPS - 1) + (s % LA_GROUPS) - 1];
            end
            cla_slice4 u_slice (
                .a      (op_a[s*SLICE_W +: SLICE_W]),
                .b      (op_b[s*SLICE_W +: SLICE_W]),
                .c_in   (sc),
                .s      (sum[s*SLICE_W +: SLICE_W]),
                .gen_n  (l_gen_n[s]),
                .prop_n (l_prop_n[s])
            );
        end else begin : g_pad
            // Empty position: pass the carry straight through.
            assign l_gen_n[s]  = 1'b1;
            assign l_prop_n[s] = 1'b0;
        end
    end

    for (genvar k = 0; k < BLOCKS; k++) begin : g_block
        cla_lookahead4 u_la (
            .grp_gen_n  (l_gen_n[k*LA_GROUPS +: LA_GROUPS]),
            .grp_prop_n (l_prop_n[k*LA_GROUPS +: LA_GROUPS]),
            .c_in       (blk_cin[k]),
            .c_grp      (lk_c[k*(LA_GROUPS-1) +: (LA_GROUPS-1)]),
            .blk_gen_n  (b_gen_n[k]),
            .blk_prop_n (b_prop_n[k])
        );
    end

    if (LEVELS == 1) begin : g_ripple
        for (genvar k = 0; k < BLOCKS; k++) begin : g_hop
            assign blk_cin[k+1] = ~b_gen_n[k] | (~b_prop_n[k] & blk_cin[k]);
        end
    end else begin : g_second
        logic [LA_GROUPS-1:0] t_gen_n;
        logic [LA_GROUPS-1:0] t_prop_n;
        logic [LA_GROUPS-2:0] t_c;
        logic                 t_g_n;
        logic                 t_p_n;
        for (genvar k = 0; k < LA_GROUPS; k++) begin : g_tin
            if (k < BLOCKS) begin : g_used
                assign t_gen_n[k]  = b_gen_n[k];
                assign t_prop_n[k] = b_prop_n[k];
            end else begin : g_empty
                assign t_gen_n[k]  = 1'b1;
                assign t_prop_n[k] = 1'b0;
            end
        end
        cla_lookahead4 u_la_top (
            .grp_gen_n  (t_gen_n),
            .grp_prop_n (t_prop_n),
            .c_in       (carry_in),
            .c_grp      (t_c),
            .blk_gen_n  (t_g_n),
            .blk_prop_n (t_p_n)
        );
        for (genvar k = 1; k < BLOCKS; k++) begin : g_bc
            assign blk_cin[k] = t_c[k-1];
        end
        assign blk_cin[BLOCKS] = ~t_g_n | (~t_p_n & carry_in);
    end

    assign carry_out = blk_cin[BLOCKS];
endmodule

// File: rtl/cla_checkers.sv
module cla_lookahead4_chk (
    input logic [3:0] grp_gen_n,
    input logic [3:0] grp_prop_n,
    input logic       c_in,
    input logic [2:0] c_grp,
    input logic       blk_gen_n,
    input logic       blk_prop_n
);
    always_comb begin
        if (!$isunknown({grp_gen_n, grp_prop_n, c_in, c_grp, blk_gen_n, blk_prop_n})) begin
            // R1
            a_r1_gen_forces: assert (grp_gen_n[0] || c_grp[0]);
            a_r1_kill_blocks: assert (!(grp_gen_n[0] && grp_prop_n[0]) || !c_grp[0]);
            // R2
            a_r2_chain: assert (c_grp[1] == (!grp_gen_n[1] || (!grp_prop_n[1] && c_grp[0])));
            // R3
            a_r3_chain: assert (c_grp[2] == (!grp_gen_n[2] || (!grp_prop_n[2] && c_grp[1])));
            // R4
            a_r4_top_gen: assert (grp_gen_n[3] || !blk_gen_n);
            a_r4_no_gen: assert (!(&grp_gen_n) || blk_gen_n);
            // R5
            a_r5_all_prop: assert ((!blk_prop_n) == (grp_prop_n == 4'b0000));
        end
    end
endmodule

module cla_adder_wide_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out
);
    logic [WIDTH:0] ref_sum;
    always_comb begin
        ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        if (!$isunknown({op_a, op_b, carry_in, sum, carry_out})) begin
            // R6
            a_r6_sum_matches: assert ({carry_out, sum} == ref_sum);
        end
    end
endmodule

bind cla_lookahead4 cla_lookahead4_chk u_la_chk (
    .grp_gen_n  (grp_gen_n),
    .grp_prop_n (grp_prop_n),
    .c_in       (c_in),
    .c_grp      (c_grp),
    .blk_gen_n  (blk_gen_n),
    .blk_prop_n (blk_prop_n)
);

bind cla_adder_wide cla_adder_wide_chk #(.WIDTH(WIDTH)) u_add_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/tb_cla_adder_wide.sv
module tb_cla_adder_wide;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // lookahead cell stimulus
    logic [3:0] la_gen_n  = 4'hF;
    logic [3:0] la_prop_n = 4'hF;
    logic       la_cin    = 1'b0;
    logic [2:0] la_c;
    logic       la_g_n, la_p_n;

    // adder stimulus, shared by all widths
    logic [31:0] va = '0, vb = '0;
    logic        vcin = 1'b0;
    logic [31:0] s32, s32l2;
    logic [15:0] s16;
    logic [27:0] s28;
    logic        c32, c32l2, c16, c28;

    cla_lookahead4 u_cla (
        .grp_gen_n(la_gen_n), .grp_prop_n(la_prop_n), .c_in(la_cin),
        .c_grp(la_c), .blk_gen_n(la_g_n), .blk_prop_n(la_p_n));

    cla_adder_wide #(.WIDTH(32), .LEVELS(1)) dut (
        .op_a(va), .op_b(vb), .carry_in(vcin), .sum(s32), .carry_out(c32));
    cla_adder_wide #(.WIDTH(16), .LEVELS(1)) u_add16 (
        .op_a(va[15:0]), .op_b(vb[15:0]), .carry_in(vcin), .sum(s16), .carry_out(c16));
    cla_adder_wide #(.WIDTH(28), .LEVELS(1)) u_add28 (
        .op_a(va[27:0]), .op_b(vb[27:0]), .carry_in(vcin), .sum(s28), .carry_out(c28));
    cla_adder_wide #(.WIDTH(32), .LEVELS(2)) u_add32l2 (
        .op_a(va), .op_b(vb), .carry_in(vcin), .sum(s32l2), .carry_out(c32l2));

    typedef struct {
        bit          is_la;
        string       tag;
        logic [4:0]  exp_la;   // {c1,c2,c3,blk_g_n,blk_p_n}
        logic [16:0] exp16;
        logic [28:0] exp28;
        logic [32:0] exp32;
    } item_t;

    item_t q[$];

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver for the lookahead cell; reference built as a ripple chain.
    task automatic drive_la(logic [3:0] gn, logic [3:0] pn, logic ci);
        item_t it;
        logic c, cb;
        logic [3:0] g, p;
        @(negedge clk);
        la_gen_n = gn; la_prop_n = pn; la_cin = ci;
        g = ~gn; p = ~pn;
        c = ci;
        c = g[0] | (p[0] & c); it.exp_la[4] = c;
        c = g[1] | (p[1] & c); it.exp_la[3] = c;
        c = g[2] | (p[2] & c); it.exp_la[2] = c;
        cb = 1'b0;
        for (int i = 0; i < 4; i++) cb = g[i] | (p[i] & cb);
        it.exp_la[1] = ~cb;
        it.exp_la[0] = ~(p == 4'hF);
        it.is_la = 1'b1;
        it.tag = "";
        it.exp16 = '0; it.exp28 = '0; it.exp32 = '0;
        q.push_back(it);
    endtask

    task automatic drive_add(logic [31:0] a, logic [31:0] b, logic ci, string tag);
        item_t it;
        @(negedge clk);
        va = a; vb = b; vcin = ci;
        it.is_la = 1'b0;
        it.tag = tag;
        it.exp_la = '0;
        it.exp32 = {1'b0, a} + {1'b0, b} + {32'd0, ci};
        it.exp16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, ci};
        it.exp28 = {1'b0, a[27:0]} + {1'b0, b[27:0]} + {28'd0, ci};
        q.push_back(it);
    endtask

    // Monitor: pops one expectation per rising edge, half a period after driving.
    always @(posedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.is_la) begin
                chk("R1 carry into group 1", 64'(la_c[0]), 64'(it.exp_la[4]));
                chk("R2 carry into group 2", 64'(la_c[1]), 64'(it.exp_la[3]));
                chk("R3 carry into group 3", 64'(la_c[2]), 64'(it.exp_la[2]));
                chk("R4 block generate",     64'(la_g_n),  64'(it.exp_la[1]));
                chk("R5 block propagate",    64'(la_p_n),  64'(it.exp_la[0]));
            end else begin
                chk({it.tag, " R6 32-bit ripple"}, 64'({c32, s32}), 64'(it.exp32));
                chk({it.tag, " R6 16-bit"},        64'({c16, s16}), 64'(it.exp16));
                chk({it.tag, " R9 28-bit"},        64'({c28, s28}), 64'(it.exp28));
                chk({it.tag, " R7 two-level"},     64'({c32l2, s32l2}), 64'(it.exp32));
            end
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1..R5: every combination of the nine inputs
        for (int i = 0; i < 512; i++) begin
            logic [8:0] v;
            v = 9'(i);
            drive_la(v[3:0], v[7:4], v[8]);
        end
        // R8: carry through every group
        drive_add(32'hFFFF_FFFF, 32'h0, 1'b1, "R8 ones+cin");
        drive_add(32'hFFFF_FFFF, 32'h1, 1'b0, "R8 ones+1");
        drive_add(32'h0FFF_FFFF, 32'h0, 1'b1, "R8 28-bit ones+cin");
        drive_add(32'h0, 32'h0, 1'b0, "R6 zero");
        // R10: a generate in slice k, every higher slice propagating
        for (int k = 0; k < 8; k++) begin
            drive_add(32'hFFFF_FFFF << (4 * k), 32'h1 << (4 * k), 1'b0, "R10 single generate");
        end
        for (int i = 0; i < 300; i++) begin
            drive_add($urandom, $urandom, 1'($urandom), "R6 random");
        end
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule